// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the software-visible side of one PS/2 keyboard or mouse port. A processor reaches it over a simple word-addressed bus with separate read and write strobes. Bytes from the device arrive on a valid/ready byte stream, and bytes for the device leave on a second stream that the block treats as always ready. The block keeps a control word and a clock-divisor word, reports whether a received byte is waiting, returns a fixed identification byte sequence at the top of its window, and drives one level-sensitive interrupt line.

Reads are combinational on the addressed word. A read of the data word consumes a waiting byte and keeps a copy of it. When no byte is waiting, the same read returns that copy again. The interrupt is the OR of two terms: a receive term gated by a control bit, and a second control bit that forces the line high on its own.

Top module: `ps2_reg_front`

## Requirements
- R1: After reset the control word, the divisor word and the held data byte all read as zero, and irqOut, rxReady and txValid are low.
- R2: The control word (index 0) and the divisor word (index 3) store all DATA_W bits written to them and return them on reads. The divisor has no other effect.
- R3: irqOut is high exactly when (rxValid is high and control bit 4 is 1) or control bit 3 is 1. A control write takes effect on irqOut in the cycle after the write.
- R4: A read of the status word (index 1) returns 0x10 while rxValid is high and 0x00 otherwise.
- R5: A read of the data word (index 2) while rxValid is high returns rxData in bits 7:0, with zeros above. rxReady is high for that read cycle only, and the byte becomes the held byte. rxReady is never high in any other cycle.
- R6: A read of the data word while rxValid is low returns the held byte unchanged and leaves rxReady low.
- R7: A read of the interrupt-status word (index 4) returns bit 0 equal to rxValid, bit 1 equal to 1, and every other bit zero.
- R8: Word indices from 2^WORD_W−8 to 2^WORD_W−1 read as the identification bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in rising index order.
- R9: A write to the data word raises txValid for that cycle, with txData equal to bits 7:0 of the write data. txValid is never high without such a write.
- R10: Reads of unmapped indices return zero. Writes to status, interrupt status, identification or unmapped indices change no stored value and raise no txValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | WORD_W | Word index within the window |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the addressed word |
| irqOut | output | 1 | Level interrupt |
| rxValid | input | 1 | Received byte waiting |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Received byte taken this cycle |
| txValid | output | 1 | Byte to send this cycle |
| txData | output | 8 | Byte to send |

## Verification
The hardest case to reach from the ports is a data read with nothing waiting after an earlier byte has been taken. Only that case shows that the held byte survives and that no second handshake is issued. The bench offers a byte, takes it with one read, withdraws rxValid as a real source would, and reads again, checking both the returned byte and that rxReady stays low. Whole-window sweeps of reads, and of writes to every non-writable index, cover the identification table and the ignored accesses. They are followed by read-backs of the control and divisor words.

// File: rtl/ps2_reg_pkg.sv
package ps2_reg_pkg;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA,
    SEL_DIV,
    SEL_INTR,
    SEL_ID
  } rdSel_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic   wrCtrl;
    logic   wrDiv;
    logic   wrTx;
    logic   take;
    rdSel_e rdSel;
    logic [2:0] idIdx;
  } strobes_t;

  localparam logic [7:0] STAT_PENDING = 8'h10;
  localparam logic [1:0] INTR_TX_READY = 2'b10;
  localparam int CTRL_RX_EN_BIT = 4;
  localparam int CTRL_FORCE_BIT = 3;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h50;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ps2_reg_ctrl.sv
module ps2_reg_ctrl
  import ps2_reg_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic [WORD_W-1:0] busAddr,
  input  logic              rxValid,
  output strobes_t          strb
);

  localparam logic [WORD_W-1:0] ID_BASE = {{(WORD_W-3){1'b1}}, 3'b000};
  localparam logic [WORD_W-1:0] IDX_CTRL = WORD_W'(0);
  localparam logic [WORD_W-1:0] IDX_STAT = WORD_W'(1);
  localparam logic [WORD_W-1:0] IDX_DATA = WORD_W'(2);
  localparam logic [WORD_W-1:0] IDX_DIV  = WORD_W'(3);
  localparam logic [WORD_W-1:0] IDX_INTR = WORD_W'(4);

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_ZERO;
    strb.idIdx = busAddr[2:0];
    if (busAddr >= ID_BASE) begin
      strb.rdSel = SEL_ID;
    end else begin
      case (busAddr)
        IDX_CTRL: begin
          strb.rdSel  = SEL_CTRL;
          strb.wrCtrl = busWr;
        end
        IDX_STAT: strb.rdSel = SEL_STAT;
        IDX_DATA: begin
          strb.rdSel = SEL_DATA;
          strb.wrTx  = busWr;
          strb.take  = busRd & rxValid;
        end
        IDX_DIV: begin
          strb.rdSel = SEL_DIV;
          strb.wrDiv = busWr;
        end
        IDX_INTR: strb.rdSel = SEL_INTR;
        default:  strb.rdSel = SEL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/ps2_reg_dpath.sv
module ps2_reg_dpath
  import ps2_reg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txData
);

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] divReg;
  logic [7:0]        heldByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      divReg   <= '0;
      heldByte <= '0;
    end else begin
      if (strb.wrCtrl) ctrlReg  <= busWdata;
      if (strb.wrDiv)  divReg   <= busWdata;
      if (strb.take)   heldByte <= rxData;
    end
  end

  always_comb begin
    busRdata = '0;
    case (strb.rdSel)
      SEL_CTRL: busRdata = ctrlReg;
      SEL_STAT: busRdata = rxValid ? DATA_W'(STAT_PENDING) : '0;
      SEL_DATA: busRdata = DATA_W'(strb.take ? rxData : heldByte);
      SEL_DIV:  busRdata = divReg;
      SEL_INTR: busRdata = DATA_W'({INTR_TX_READY[1], rxValid});
      SEL_ID:   busRdata = DATA_W'(idByte(strb.idIdx));
      default:  busRdata = '0;
    endcase
  end

  assign irqOut  = (rxValid & ctrlReg[CTRL_RX_EN_BIT]) | ctrlReg[CTRL_FORCE_BIT];
  assign rxReady = strb.take;
  assign txValid = strb.wrTx;
  assign txData  = busWdata[7:0];

endmodule

// File: rtl/ps2_reg_front.sv
module ps2_reg_front
  import ps2_reg_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txData
);

  strobes_t strb;

  ps2_reg_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .rxValid (rxValid),
    .strb    (strb)
  );

  ps2_reg_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .rxReady  (rxReady),
    .txValid  (txValid),
    .txData   (txData)
  );

endmodule

// File: rtl/ps2_reg_chk.sv
module ps2_reg_chk #(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              rxValid,
  input logic              rxReady,
  input logic              txValid
);

  localparam logic [WORD_W-1:0] I_CTRL = WORD_W'(0);
  localparam logic [WORD_W-1:0] I_STAT = WORD_W'(1);
  localparam logic [WORD_W-1:0] I_DATA = WORD_W'(2);
  localparam logic [WORD_W-1:0] I_INTR = WORD_W'(4);

  // R1: line is low on leaving reset
  p_irq_low_after_reset_r1: assert property (@(posedge clk)
    $rose(rstN) |-> !irqOut);

  // R3: force bit written high drives the line next cycle
  p_force_sets_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == I_CTRL && busWdata[3]) |=> irqOut);

  // R3: both source bits cleared drops the line next cycle
  p_clear_drops_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == I_CTRL && !busWdata[3] && !busWdata[4]) |=> !irqOut);

  // R4
  p_status_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == I_STAT) |-> busRdata == (rxValid ? DATA_W'(8'h10) : '0));

  // R5
  p_ready_on_data_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> (rxValid && busRd && busAddr == I_DATA));

  // R7
  p_intr_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == I_INTR) |-> busRdata == DATA_W'({1'b1, rxValid}));

  // R9
  p_tx_only_on_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (busWr && busAddr == I_DATA));

endmodule

bind ps2_reg_front ps2_reg_chk #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .txValid  (txValid)
);

// File: tb/tb_ps2_reg_front.sv
`timescale 1ns/1ps
module tb_ps2_reg_front;

  localparam int WORD_W = 10;
  localparam int DATA_W = 32;
  localparam int NWORDS = 1 << WORD_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [WORD_W-1:0] busAddr = '0;
  logic              busRd = 1'b0;
  logic              busWr = 1'b0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              irqOut;
  logic              rxValid = 1'b0;
  logic [7:0]        rxData = '0;
  logic              rxReady;
  logic              txValid;
  logic [7:0]        txData;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ps2_reg_front #(.WORD_W(WORD_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData)
  );

  logic [7:0] idTab [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later, commit at posedge
  task automatic busWrite(input int idx, input logic [DATA_W-1:0] val,
                          output logic txv, output logic [7:0] txd);
    @(negedge clk);
    busAddr = WORD_W'(idx); busWdata = val; busWr = 1'b1;
    #1;
    txv = txValid; txd = txData;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input int idx, output logic [DATA_W-1:0] val,
                         output logic rdy);
    @(negedge clk);
    busAddr = WORD_W'(idx); busRd = 1'b1;
    #1;
    val = busRdata; rdy = rxReady;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  function automatic logic [DATA_W-1:0] expRead(input int idx,
      input logic [DATA_W-1:0] c, input logic [DATA_W-1:0] d, input logic [7:0] h);
    if (idx >= NWORDS - 8) return DATA_W'(idTab[idx - (NWORDS - 8)]);
    case (idx)
      0: return c;
      1: return '0;
      2: return DATA_W'(h);
      3: return d;
      4: return DATA_W'(2);
      default: return '0;
    endcase
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    logic r, tv;
    logic [7:0] td;
    logic [DATA_W-1:0] ctrlVal, divVal;

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1
    chk("R1 irq", irqOut, 0);
    chk("R1 rxReady", rxReady, 0);
    chk("R1 txValid", txValid, 0);
    busRead(0, v, r); chk("R1 ctrl", v, 0);
    busRead(3, v, r); chk("R1 div", v, 0);
    busRead(2, v, r); chk("R1 held byte", v, 0);

    // R2
    ctrlVal = 32'hA5A5_0060; divVal = 32'h1234_5678;
    busWrite(0, ctrlVal, tv, td);
    busWrite(3, divVal, tv, td);
    busRead(0, v, r); chk("R2 ctrl", v, ctrlVal);
    busRead(3, v, r); chk("R2 div", v, divVal);
    chk("R2 no irq", irqOut, 0);

    // R4 R5 R6 R7
    @(negedge clk); rxValid = 1'b1; rxData = 8'h3C;
    busRead(1, v, r); chk("R4 pending", v, 32'h10); chk("R5 no ready on status", r, 0);
    busRead(4, v, r); chk("R7 pending", v, 3);
    busRead(2, v, r); chk("R5 data", v, 32'h3C); chk("R5 ready", r, 1);
    rxValid = 1'b0; rxData = 8'hEE;
    #1; chk("R5 ready one cycle", rxReady, 0);
    busRead(2, v, r); chk("R6 repeat", v, 32'h3C); chk("R6 no ready", r, 0);
    busRead(1, v, r); chk("R4 idle", v, 0);
    busRead(4, v, r); chk("R7 idle", v, 2);

    // R9
    busWrite(2, 32'hDEAD_BE77, tv, td);
    chk("R9 txValid", tv, 1); chk("R9 txData", td, 8'h77);
    #1; chk("R9 txValid drops", txValid, 0);
    busRead(2, v, r); chk("R9 held byte kept", v, 32'h3C);

    // R3 sweep: bits 3 and 4 against pending
    for (int k = 0; k < 8; k++) begin
      logic f3, f4, p;
      f3 = k[0]; f4 = k[1]; p = k[2];
      busWrite(0, {27'h0, f4, f3, 3'b000}, tv, td);
      rxValid = p;
      #1; chk("R3 irq", irqOut, (p & f4) | f3);
    end
    rxValid = 1'b0;
    busWrite(0, ctrlVal, tv, td);

    // R8 R10: full read sweep
    for (int i = 0; i < NWORDS; i++) begin
      busRead(i, v, r);
      chk((i >= NWORDS - 8) ? "R8 id" : "R10 read", v, expRead(i, ctrlVal, divVal, 8'h3C));
    end

    // R10: writes to non-writable indices
    for (int i = 0; i < NWORDS; i++) begin
      if (i == 0 || i == 2 || i == 3) continue;
      busWrite(i, '1, tv, td);
      if (tv !== 1'b0) chk("R10 no tx", tv, 0);
    end
    checks++;
    busRead(0, v, r); chk("R10 ctrl kept", v, ctrlVal);
    busRead(3, v, r); chk("R10 div kept", v, divVal);
    busRead(2, v, r); chk("R10 held kept", v, 32'h3C);
    chk("R10 irq kept", irqOut, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule